// File: doc/BRIEF.md
# Privilege and illegal-operation trap unit

This unit sits in the execute stage of a simple in-order processor core. For each issued operation it receives the decoded operation class, the top bit of the special-register number, an illegal-operation flag from decode, the address of the current operation and the current machine state word. From these it decides one of three outcomes: the operation proceeds, the core halts, or the operation traps.

On a trap the unit returns three register updates. The first is the saved return address. The second is a saved copy of the state word, with a reason bit marking why the trap was taken. The third is a rewritten machine state word. It also redirects the next fetch to a fixed vector. When the operation proceeds, the next address is the current one plus the operation step. A halt is sticky: once the core has halted, later operations are dropped until reset.

Each result is registered and appears one clock after the operation is issued. The decoder and the register file sit outside the unit. They consume the write enables and values it returns.

State-word bits below use most-significant-first numbering: bit n is vector index 63-n. The problem-state (user mode) bit is bit 49. The other bits used are listed in R6 and R7.

Top module: `trap_unit`

## Requirements
- R1: While reset is held and after it is released, with no issue, res_vld, took_trap, halt_evt, halted and all three write enables are 0, and next_pc is 0.
- R2: An issued operation that is neither privileged-in-user-mode, nor the halt class, nor flagged illegal gives res_vld=1 one cycle later, with next_pc equal to cur_pc plus 4 and all write enables at 0.
- R3: The op_class codes 1 (halt), 2 (read state word), 3 (write state word), 4 (write state word, doubleword form) and 5 (return from interrupt) are privileged. Such an operation traps when state bit 49 is 1 and does not trap for privilege when that bit is 0.
- R4: The op_class codes 6 (read special register) and 7 (write special register) are privileged only when spr_hi is 1. Code 0 is never privileged.
- R5: A trap sets took_trap, epc_we, esave_we and st_we, gives epc_val equal to cur_pc, and sets next_pc to 0x700.
- R6: On a trap, esave_val equals state_in with one reason bit set: bit 45 for a privilege trap, or bit 44 for an illegal-operation trap.
- R7: On a trap, st_val equals state_in with bits 5, 29, 30, 31, 38, 40, 48, 49, 50, 52, 55, 58, 59, 60 and 62 cleared, and bits 0 and 63 set.
- R8: An operation with illegal=1 that is not trapped for privilege and is not the halt class traps with the illegal reason.
- R9: A halt-class operation that does not trap for privilege gives halt_evt=1, raises halted, and writes nothing. Its next_pc equals cur_pc.
- R10: halted stays 1 until reset. While halted, issued operations give no result (res_vld=0 and no writes) and leave next_pc unchanged.
- R11: The privilege check takes priority over the halt check, which takes priority over the illegal check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An operation is presented this cycle |
| op_class | input | 3 | Decoded operation class (codes in R3, R4) |
| spr_hi | input | 1 | Top bit of the special-register number |
| illegal | input | 1 | Decode found the operation illegal |
| cur_pc | input | 64 | Address of the issued operation |
| state_in | input | 64 | Current machine state word |
| res_vld | output | 1 | A result for an issued operation |
| took_trap | output | 1 | The result is a trap |
| halt_evt | output | 1 | The result is a halt |
| halted | output | 1 | Sticky halted status |
| epc_we | output | 1 | Write enable for the saved return address |
| epc_val | output | 64 | Saved return address |
| esave_we | output | 1 | Write enable for the saved state copy |
| esave_val | output | 64 | Saved state copy with the reason bit |
| st_we | output | 1 | Write enable for the machine state word |
| st_val | output | 64 | Rewritten machine state word |
| next_pc | output | 64 | Redirect or sequential next address |

## Verification
Every result of this unit lands exactly one clock after its operation is issued. This holds for outcome flags, write enables, values and next_pc alike. The sticky halted flag rises on that same edge. The driver applies an operation on a falling edge and queues what it expects. The monitor pops one entry a short delay after the following rising edge, so each comparison sees the register outputs after their single cycle of latency. A dropped operation after a halt still queues an entry that expects res_vld=0, so the absence of a result is checked in the cycle where a result would have appeared.

// File: rtl/trap_unit_pkg.sv
package trap_unit_pkg;

    localparam int unsigned SW = 64;

    typedef enum logic [2:0] {
        OPC_PLAIN    = 3'd0,
        OPC_HALT     = 3'd1,
        OPC_RD_ST    = 3'd2,
        OPC_WR_ST    = 3'd3,
        OPC_WR_ST_D  = 3'd4,
        OPC_RET_INT  = 3'd5,
        OPC_RD_SPR   = 3'd6,
        OPC_WR_SPR   = 3'd7
    } op_class_e;

    typedef enum logic [1:0] {
        OUT_PROCEED  = 2'd0,
        OUT_TRAP_PRV = 2'd1,
        OUT_TRAP_ILL = 2'd2,
        OUT_HALT     = 2'd3
    } outcome_e;

    // state-word bit numbers, most-significant-first
    localparam int unsigned NB_USER  = 49;
    localparam int unsigned NB_WIDE  = 0;
    localparam int unsigned NB_LEND  = 63;
    localparam int unsigned NB_RSN_P = 45;
    localparam int unsigned NB_RSN_I = 44;
    localparam int unsigned N_CLR    = 15;
    localparam int unsigned CLR_NB [N_CLR] =
        '{5, 29, 30, 31, 38, 40, 48, 49, 50, 52, 55, 58, 59, 60, 62};

    function automatic logic [5:0] nb2idx(input int unsigned nb);
        return 6'(SW - 1 - nb);
    endfunction

    function automatic logic [SW-1:0] clr_mask();
        logic [SW-1:0] m;
        m = '0;
        for (int i = 0; i < int'(N_CLR); i++) begin
            m[nb2idx(CLR_NB[i])] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [SW-1:0] set_mask();
        logic [SW-1:0] m;
        m = '0;
        m[nb2idx(NB_WIDE)] = 1'b1;
        m[nb2idx(NB_LEND)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/trap_decide.sv
module trap_decide
    import trap_unit_pkg::*;
(
    input  logic [2:0] op_class,
    input  logic       spr_hi,
    input  logic       illegal,
    input  logic       user_mode,
    output outcome_e   outcome
);
    logic priv_cls;

    always_comb begin
        unique case (op_class_e'(op_class))
            OPC_HALT, OPC_RD_ST, OPC_WR_ST,
            OPC_WR_ST_D, OPC_RET_INT: priv_cls = 1'b1;
            OPC_RD_SPR, OPC_WR_SPR:   priv_cls = spr_hi;
            default:                  priv_cls = 1'b0;
        endcase
    end

    always_comb begin
        if (priv_cls && user_mode)
            outcome = OUT_TRAP_PRV;
        else if (op_class_e'(op_class) == OPC_HALT)
            outcome = OUT_HALT;
        else if (illegal)
            outcome = OUT_TRAP_ILL;
        else
            outcome = OUT_PROCEED;
    end

    // R11
    prio_chk: assert final (!(priv_cls && user_mode) || outcome == OUT_TRAP_PRV);
endmodule

// File: rtl/trap_state_build.sv
module trap_state_build
    import trap_unit_pkg::*;
(
    input  logic [SW-1:0] state_in,
    input  logic          rsn_priv,
    output logic [SW-1:0] save_copy,
    output logic [SW-1:0] new_state
);
    localparam logic [SW-1:0] CLR = clr_mask();
    localparam logic [SW-1:0] SET = set_mask();

    logic [SW-1:0] rsn_bit;

    always_comb begin
        rsn_bit = '0;
        if (rsn_priv) rsn_bit[nb2idx(NB_RSN_P)] = 1'b1;
        else          rsn_bit[nb2idx(NB_RSN_I)] = 1'b1;
        save_copy = state_in | rsn_bit;
        new_state = (state_in & ~CLR) | SET;
    end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
    import trap_unit_pkg::*;
#(
    parameter logic [63:0] TRAP_VEC = 64'h700,
    parameter int unsigned STEP     = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue_vld,
    input  logic [2:0]  op_class,
    input  logic        spr_hi,
    input  logic        illegal,
    input  logic [63:0] cur_pc,
    input  logic [63:0] state_in,
    output logic        res_vld,
    output logic        took_trap,
    output logic        halt_evt,
    output logic        halted,
    output logic        epc_we,
    output logic [63:0] epc_val,
    output logic        esave_we,
    output logic [63:0] esave_val,
    output logic        st_we,
    output logic [63:0] st_val,
    output logic [63:0] next_pc
);
    localparam logic [5:0] USER_IDX = nb2idx(NB_USER);

    typedef struct packed {
        logic          vld;
        logic          trap;
        logic          hlt;
        logic          halted;
        logic          wr;
        logic [SW-1:0] epc;
        logic [SW-1:0] esave;
        logic [SW-1:0] st;
        logic [SW-1:0] npc;
    } res_t;

    res_t          r_d, r_q;
    outcome_e      outcome;
    logic [SW-1:0] save_copy, new_state;

    trap_decide u_decide (
        .op_class  (op_class),
        .spr_hi    (spr_hi),
        .illegal   (illegal),
        .user_mode (state_in[USER_IDX]),
        .outcome   (outcome)
    );

    trap_state_build u_build (
        .state_in  (state_in),
        .rsn_priv  (outcome == OUT_TRAP_PRV),
        .save_copy (save_copy),
        .new_state (new_state)
    );

    always_comb begin
        r_d        = r_q;
        r_d.vld    = 1'b0;
        r_d.trap   = 1'b0;
        r_d.hlt    = 1'b0;
        r_d.wr     = 1'b0;
        if (issue_vld && !r_q.halted) begin
            r_d.vld = 1'b1;
            unique case (outcome)
                OUT_TRAP_PRV, OUT_TRAP_ILL: begin
                    r_d.trap  = 1'b1;
                    r_d.wr    = 1'b1;
                    r_d.epc   = cur_pc;
                    r_d.esave = save_copy;
                    r_d.st    = new_state;
                    r_d.npc   = TRAP_VEC;
                end
                OUT_HALT: begin
                    r_d.hlt    = 1'b1;
                    r_d.halted = 1'b1;
                    r_d.npc    = cur_pc;
                end
                default: r_d.npc = cur_pc + 64'(STEP);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign res_vld   = r_q.vld;
    assign took_trap = r_q.trap;
    assign halt_evt  = r_q.hlt;
    assign halted    = r_q.halted;
    assign epc_we    = r_q.wr;
    assign esave_we  = r_q.wr;
    assign st_we     = r_q.wr;
    assign epc_val   = r_q.epc;
    assign esave_val = r_q.esave;
    assign st_val    = r_q.st;
    assign next_pc   = r_q.npc;

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10
    halted_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && issue_vld) |=> (!res_vld && !st_we));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && !halted) |=> res_vld);

    // R5
    vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        took_trap |-> (next_pc == TRAP_VEC && epc_we && res_vld));

    // R7
    user_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> (!st_val[USER_IDX] && st_val[nb2idx(NB_WIDE)]));

    // R11
    halt_in_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && !halted && op_class == 3'd1 && state_in[USER_IDX])
        |=> (took_trap && !halt_evt));

    // R9
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({took_trap, halt_evt}));
endmodule

// File: tb/trap_unit_test.sv
module trap_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [2:0]  op_class = '0;
    logic        spr_hi = 1'b0;
    logic        illegal = 1'b0;
    logic [63:0] cur_pc = '0;
    logic [63:0] state_in = '0;
    logic        res_vld, took_trap, halt_evt, halted;
    logic        epc_we, esave_we, st_we;
    logic [63:0] epc_val, esave_val, st_val, next_pc;

    always #4 clk = ~clk;

    trap_unit uut (.*);

    typedef struct {
        logic        vld;
        logic        trap;
        logic        hlt;
        logic        hal;
        logic [63:0] epc;
        logic [63:0] esave;
        logic [63:0] st;
        logic [63:0] npc;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0;
    int   checks = 0;
    bit   done = 0;
    logic [63:0] last_npc = '0;
    bit   halted_m = 0;

    function automatic logic [63:0] bitn(input int n);
        return 64'd1 << (63 - n);
    endfunction

    function automatic logic [63:0] rewrite(input logic [63:0] s);
        int clr[15] = '{58, 59, 52, 55, 48, 62, 31, 38, 40, 49, 50, 60, 29, 30, 5};
        logic [63:0] r = s;
        foreach (clr[i]) r &= ~bitn(clr[i]);
        return r | bitn(0) | bitn(63);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: apply one operation and queue the expected result
    task automatic issue(input int opc, input bit hi, input bit ill,
                         input logic [63:0] pc, input logic [63:0] st, input string tag);
        exp_t e;
        bit user, priv;
        @(negedge clk);
        issue_vld = 1'b1; op_class = 3'(opc); spr_hi = hi; illegal = ill;
        cur_pc = pc; state_in = st;
        user = (st & bitn(49)) != 0;
        priv = (opc >= 1 && opc <= 5) || (opc >= 6 && hi);
        e.tag = tag; e.trap = 0; e.hlt = 0; e.epc = 'x; e.esave = 'x; e.st = 'x;
        if (halted_m) begin
            e.vld = 0; e.npc = last_npc;
        end else begin
            e.vld = 1;
            if (priv && user) begin
                e.trap = 1; e.epc = pc; e.esave = st | bitn(45);
                e.st = rewrite(st); e.npc = 64'h700;
            end else if (opc == 1) begin
                e.hlt = 1; e.npc = pc; halted_m = 1;
            end else if (ill) begin
                e.trap = 1; e.epc = pc; e.esave = st | bitn(44);
                e.st = rewrite(st); e.npc = 64'h700;
            end else begin
                e.npc = pc + 64'd4;
            end
            last_npc = e.npc;
        end
        e.hal = halted_m;
        exp_q.push_back(e);
        @(negedge clk);
        issue_vld = 1'b0;
    endtask

    // monitor: compare one cycle after each issue
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, " res_vld"}, 64'(res_vld), 64'(e.vld));
            chk({e.tag, " trap"}, 64'(took_trap), 64'(e.trap));
            chk({e.tag, " halt_evt"}, 64'(halt_evt), 64'(e.hlt));
            chk({"R10 ", e.tag, " halted"}, 64'(halted), 64'(e.hal));
            chk({e.tag, " we"}, {61'd0, epc_we, esave_we, st_we}, e.trap ? 64'd7 : 64'd0);
            chk({e.tag, " next_pc"}, next_pc, e.npc);
            if (e.trap) begin
                chk({"R5 ", e.tag, " epc"}, epc_val, e.epc);
                chk({"R6 ", e.tag, " esave"}, esave_val, e.esave);
                chk({"R7 ", e.tag, " state"}, st_val, e.st);
            end
        end
    end

    task automatic reset_check();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        halted_m = 0; last_npc = '0;
        @(negedge clk);
        chk("R1 reset outs", {57'd0, res_vld, took_trap, halt_evt, halted, epc_we, esave_we, st_we}, 64'd0);
        chk("R1 reset next_pc", next_pc, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] usr;
        usr = bitn(49) | bitn(1) | 64'h0000_0000_00F0_0000;
        reset_check();
        issue(0, 0, 0, 64'h1000, 64'h0, "R2 plain");
        issue(0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFC, usr, "R2 plain user wrap");
        issue(2, 0, 0, 64'h2000, 64'h0, "R3 rd_st supervisor");
        issue(2, 0, 0, 64'h2004, usr, "R3 rd_st user");
        issue(3, 0, 0, 64'h2008, usr, "R3 wr_st user");
        issue(4, 0, 0, 64'h200C, usr, "R3 wr_st_d user");
        issue(5, 0, 0, 64'h2010, usr, "R3 ret_int user");
        issue(7, 0, 0, 64'h3000, usr, "R4 wr_spr lo user");
        issue(6, 1, 0, 64'h3004, usr, "R4 rd_spr hi user");
        issue(7, 1, 0, 64'h3008, 64'h0, "R4 wr_spr hi supervisor");
        issue(0, 1, 0, 64'h300C, usr, "R4 plain hi user");
        issue(0, 0, 1, 64'h4000, 64'h0, "R8 illegal supervisor");
        issue(0, 0, 1, 64'h4004, usr, "R8 illegal user");
        issue(3, 0, 1, 64'h4008, usr, "R11 priv over illegal");
        issue(2, 0, 0, 64'h5000, '1, "R7 all ones");
        issue(1, 0, 0, 64'h5004, usr | bitn(44), "R11 halt in user traps");
        issue(1, 0, 1, 64'h6000, 64'h0, "R11 halt over illegal");
        issue(0, 0, 0, 64'h6004, 64'h0, "R10 after halt");
        issue(0, 0, 1, 64'h6008, usr, "R10 illegal after halt");
        issue(1, 0, 0, 64'h600C, 64'h0, "R10 halt after halt");
        repeat (3) @(negedge clk);
        chk("R10 halted held", 64'(halted), 64'd1);
        reset_check();
        issue(0, 0, 0, 64'h7000, 64'h0, "R9 runs after reset");
        issue(1, 0, 0, 64'h7004, 64'h0, "R9 halt supervisor");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule